// File: doc/BRIEF.md
# Reset Manager with Pulse Stretcher

This block turns supply-level reset events and explicit requests into an ordered set of reset outputs, all clocked by a slow always-on clock. A core-supply reset input, active low, stands for power-on, brownout or regulator-loss events. It goes through an asynchronous-assert, synchronous-deassert stage and then causes a general reset. A second input asks for the active-low external reset line to be asserted.

Each reset sequence holds the external line low for a programmable stretch. The stretch is 2^(L+1) slow-clock cycles, where L is a 4-bit length field in a small mode register. After the external line is released, a fixed two-cycle startup interval runs. The processor and peripheral resets are then released together. At that same edge a reset-type code is written into a status field.

The length field can be written at any time and read back. It is cleared only by a general reset, so a programmed length still shapes every later requested reset.

Top module: `rstmgr_top`

## Requirements
- R1: While `core_rst_n` is low, `ext_rst_n`, `proc_rst_n` and `periph_rst_n` are all low, and `len_rd` and `rst_type` read 0. Writes to the length field have no effect while `core_rst_n` is low.
- R2: After a general reset, with the length field cleared, `ext_rst_n` is low after the 3rd rising clock edge that follows the rise of `core_rst_n` and high after the 4th. Two of those edges are synchroniser latency and two are the pulse itself.
- R3: A request (`ext_req` high at a rising edge while no sequence is running) drives `ext_rst_n` low for exactly 2^(L+1) clock cycles, where L is the current `len_rd` value.
- R4: With L = 0 the requested external pulse lasts exactly 2 cycles.
- R5: `proc_rst_n` and `periph_rst_n` rise on the same edge, exactly 2 cycles after `ext_rst_n` rises. Neither is high while `ext_rst_n` is low.
- R6: `rst_type` changes only on the edge where `proc_rst_n` rises. It is loaded with 0 after a general reset and with 4 after a requested reset. During a sequence it keeps its previous value.
- R7: The length field is loaded by `wr_en` with `wr_len` and keeps its value through requested resets. A general reset clears it to 0.
- R8: `ext_req` asserted while a pulse or the startup interval is running neither restarts nor shortens the sequence.
- R9: A length write during a running pulse does not change that pulse's length, but it is visible on `len_rd` and applies to the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| core_rst_n | input | 1 | Core-supply reset, active low, asynchronous |
| ext_req | input | 1 | Request to assert the external reset line |
| wr_en | input | 1 | Length-field write strobe |
| wr_len | input | 4 | Length field write data |
| ext_rst_n | output | 1 | External reset line, active low |
| proc_rst_n | output | 1 | Processor reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| len_rd | output | 4 | Length field readback |
| rst_type | output | 3 | Reset-type status, 0 = general, 4 = requested |

## Verification
The pulse stretcher is driven with requests at length values 0, 1, 2, 3, 5 and 15. This spans the minimum pulse, small powers of two that expose off-by-one counting, and the full 17-bit count that exposes counter truncation. Each request also measures the startup gap and the type code, which separates a status field that updates early from one that updates at processor release. Directed cases cover the following:
- the exact release edge after a general reset;
- re-requests during the pulse and during startup, which show any restart or early end;
- a length write in mid-pulse, which shows whether the running count was latched;
- a general reset after a nonzero length, which shows whether the field clears.

// File: rtl/rstmgr_pkg.sv
package rstmgr_pkg;
    localparam int LEN_W       = 4;
    localparam int CNT_W       = (1 << LEN_W) + 1;
    localparam int STARTUP_CYC = 2;
    localparam int SYNC_STAGES = 2;
    localparam int TYPE_W      = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PULSE   = 2'd1,
        ST_STARTUP = 2'd2
    } seq_state_e;

    typedef enum logic [TYPE_W-1:0] {
        RT_GENERAL = 3'd0,
        RT_EXTREQ  = 3'd4
    } rst_type_e;

    typedef struct packed {
        logic ext_n;
        logic proc_n;
        logic periph_n;
    } rst_out_t;

    function automatic logic [CNT_W-1:0] pulse_len(input logic [LEN_W-1:0] field);
        logic [CNT_W-1:0] one;
        one = {{(CNT_W-1){1'b0}}, 1'b1};
        return one << (int'(field) + 1);
    endfunction
endpackage

// File: rtl/rstmgr_rst_sync.sv
module rstmgr_rst_sync #(
    parameter int STAGES = rstmgr_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], 1'b1};
        end
    end

    assign rst_o = ~chain[STAGES-1];
endmodule

// File: rtl/rstmgr_mode_reg.sv
module rstmgr_mode_reg #(
    parameter int LEN_W = rstmgr_pkg::LEN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_len,
    output logic [LEN_W-1:0] len_q
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            len_q <= '0;
        end else if (wr_en) begin
            len_q <= wr_len;
        end
    end
endmodule

// File: rtl/rstmgr_seq.sv
module rstmgr_seq
    import rstmgr_pkg::*;
#(
    parameter int LEN_W   = rstmgr_pkg::LEN_W,
    parameter int CNT_W   = (1 << LEN_W) + 1,
    parameter int STARTUP = rstmgr_pkg::STARTUP_CYC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [LEN_W-1:0]  len,
    output rst_out_t          outs,
    output logic [TYPE_W-1:0] status
);
    localparam logic [CNT_W-1:0] CNT_ONE   = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_START = CNT_W'(STARTUP);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    rst_type_e        pend;

    function automatic logic [CNT_W-1:0] load_len(input logic [LEN_W-1:0] f);
        return CNT_ONE << (int'(f) + 1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_PULSE;
            cnt    <= load_len('0);
            pend   <= RT_GENERAL;
            status <= RT_GENERAL;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        state <= ST_PULSE;
                        cnt   <= load_len(len);
                        pend  <= RT_EXTREQ;
                    end
                end
                ST_PULSE: begin
                    if (cnt == CNT_ONE) begin
                        state <= ST_STARTUP;
                        cnt   <= CNT_START;
                    end else begin
                        cnt <= cnt - CNT_ONE;
                    end
                end
                ST_STARTUP: begin
                    if (cnt == CNT_ONE) begin
                        state  <= ST_IDLE;
                        status <= pend;
                    end else begin
                        cnt <= cnt - CNT_ONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        outs.ext_n    = !rst && (state != ST_PULSE);
        outs.proc_n   = !rst && (state == ST_IDLE);
        outs.periph_n = !rst && (state == ST_IDLE);
    end
endmodule

// File: rtl/rstmgr_top.sv
module rstmgr_top
    import rstmgr_pkg::*;
#(
    parameter int LEN_W = rstmgr_pkg::LEN_W
) (
    input  logic              clk,
    input  logic              core_rst_n,
    input  logic              ext_req,
    input  logic              wr_en,
    input  logic [LEN_W-1:0]  wr_len,
    output logic              ext_rst_n,
    output logic              proc_rst_n,
    output logic              periph_rst_n,
    output logic [LEN_W-1:0]  len_rd,
    output logic [TYPE_W-1:0] rst_type
);
    logic     gen_rst;
    rst_out_t outs;

    rstmgr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (core_rst_n),
        .rst_o  (gen_rst)
    );

    rstmgr_mode_reg #(.LEN_W(LEN_W)) u_mode (
        .clk    (clk),
        .rst    (gen_rst),
        .wr_en  (wr_en),
        .wr_len (wr_len),
        .len_q  (len_rd)
    );

    rstmgr_seq #(.LEN_W(LEN_W), .STARTUP(STARTUP_CYC)) u_seq (
        .clk    (clk),
        .rst    (gen_rst),
        .req    (ext_req),
        .len    (len_rd),
        .outs   (outs),
        .status (rst_type)
    );

    assign ext_rst_n    = outs.ext_n;
    assign proc_rst_n   = outs.proc_n;
    assign periph_rst_n = outs.periph_n;
endmodule

// File: rtl/rstmgr_chk.sv
module rstmgr_chk #(
    parameter int LEN_W  = 4,
    parameter int TYPE_W = 3
) (
    input logic              clk,
    input logic              core_rst_n,
    input logic              gen_rst,
    input logic              wr_en,
    input logic              ext_rst_n,
    input logic              proc_rst_n,
    input logic              periph_rst_n,
    input logic [LEN_W-1:0]  len_rd,
    input logic [TYPE_W-1:0] rst_type
);
    always @(posedge clk) begin
        if (!core_rst_n) begin
            AST_GEN_ALL_LOW: assert (!ext_rst_n && !proc_rst_n && !periph_rst_n); // R1
        end
    end

    AST_EXT_MIN_TWO: assert property (@(posedge clk) disable iff (gen_rst)
        $fell(ext_rst_n) |=> !ext_rst_n); // R3

    AST_PROC_NOT_BEFORE_EXT: assert property (@(posedge clk) disable iff (gen_rst)
        !ext_rst_n |-> (!proc_rst_n && !periph_rst_n)); // R5

    AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (gen_rst)
        $rose(proc_rst_n) |-> (ext_rst_n && $past(ext_rst_n) && !$past(ext_rst_n, 3))); // R5

    AST_PERIPH_WITH_PROC: assert property (@(posedge clk) disable iff (gen_rst)
        $rose(proc_rst_n) |-> $rose(periph_rst_n)); // R5

    AST_TYPE_AT_RELEASE: assert property (@(posedge clk) disable iff (gen_rst)
        !$stable(rst_type) |-> $rose(proc_rst_n)); // R6

    AST_LEN_HELD: assert property (@(posedge clk) disable iff (gen_rst)
        !wr_en |=> $stable(len_rd)); // R7
endmodule

bind rstmgr_top rstmgr_chk #(.LEN_W(LEN_W), .TYPE_W(rstmgr_pkg::TYPE_W)) u_chk (
    .clk          (clk),
    .core_rst_n   (core_rst_n),
    .gen_rst      (gen_rst),
    .wr_en        (wr_en),
    .ext_rst_n    (ext_rst_n),
    .proc_rst_n   (proc_rst_n),
    .periph_rst_n (periph_rst_n),
    .len_rd       (len_rd),
    .rst_type     (rst_type)
);

// File: tb/rstmgr_top_tb.sv
module rstmgr_top_tb;
    logic       clk = 1'b0;
    logic       core_rst_n = 1'b0;
    logic       ext_req = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_len = 4'd0;
    logic       ext_rst_n, proc_rst_n, periph_rst_n;
    logic [3:0] len_rd;
    logic [2:0] rst_type;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    localparam int NV = 6;
    localparam logic [3:0] VEC_LEN [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd15};
    localparam int         VEC_LO  [NV] = '{2, 4, 8, 16, 64, 65536};

    rstmgr_top u_dut (
        .clk          (clk),
        .core_rst_n   (core_rst_n),
        .ext_req      (ext_req),
        .wr_en        (wr_en),
        .wr_len       (wr_len),
        .ext_rst_n    (ext_rst_n),
        .proc_rst_n   (proc_rst_n),
        .periph_rst_n (periph_rst_n),
        .len_rd       (len_rd),
        .rst_type     (rst_type)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
                finish_run();
            end
        end
    end

    task automatic write_len(input logic [3:0] v);
        wr_en = 1'b1;
        wr_len = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Starts at a negedge with the block idle. Counts the low samples of
    // ext_rst_n, then the samples with ext high and proc low.
    // poke_mode: 0 none, 1 re-request at low sample poke_at,
    // 2 write poke_len at low sample poke_at, 3 re-request in startup.
    task automatic run_req(input int poke_mode, input int poke_at,
                           input logic [3:0] poke_len,
                           output int lo, output int su, output int mid_type);
        lo = 0;
        su = 0;
        mid_type = -1;
        ext_req = 1'b1;
        @(negedge clk);
        ext_req = 1'b0;
        while (!ext_rst_n && lo < 70000) begin
            lo++;
            if (lo == 1) mid_type = int'(rst_type);
            if (lo == poke_at && poke_mode == 1) ext_req = 1'b1;
            if (lo == poke_at && poke_mode == 2) begin
                wr_en = 1'b1;
                wr_len = poke_len;
            end
            @(negedge clk);
            ext_req = 1'b0;
            wr_en = 1'b0;
        end
        while (ext_rst_n && !proc_rst_n && su < 10) begin
            su++;
            chk("R5 periph held with proc", int'(periph_rst_n), int'(proc_rst_n));
            if (poke_mode == 3 && su == 1) ext_req = 1'b1;
            @(negedge clk);
            ext_req = 1'b0;
        end
        chk("R5 periph released with proc", int'(periph_rst_n), 1);
    endtask

    task automatic general_reset();
        @(negedge clk);
        core_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 ext low in general reset", int'(ext_rst_n), 0);
        chk("R1 proc low in general reset", int'(proc_rst_n), 0);
        chk("R1 periph low in general reset", int'(periph_rst_n), 0);
        chk("R1 len cleared", int'(len_rd), 0);
        chk("R1 type cleared", int'(rst_type), 0);
        write_len(4'd9);
        chk("R1 write ignored in reset", int'(len_rd), 0);
    endtask

    task automatic release_general();
        int ext_at [7];
        int proc_at [7];
        core_rst_n = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(posedge clk);
            @(negedge clk);
            ext_at[k] = int'(ext_rst_n);
            proc_at[k] = int'(proc_rst_n);
        end
        chk("R2 ext low after 3rd edge", ext_at[3], 0);
        chk("R2 ext high after 4th edge", ext_at[4], 1);
        chk("R5 proc low after 5th edge", proc_at[5], 0);
        chk("R5 proc high after 6th edge", proc_at[6], 1);
        chk("R6 type general after release", int'(rst_type), 0);
    endtask

    initial begin
        int lo, su, mt, prev_type;
        @(negedge clk);
        general_reset();
        release_general();

        prev_type = 0;
        for (int i = 0; i < NV; i++) begin
            write_len(VEC_LEN[i]);
            chk("R7 len readback", int'(len_rd), int'(VEC_LEN[i]));
            run_req(0, 0, 4'd0, lo, su, mt);
            if (VEC_LEN[i] == 4'd0) chk("R4 zero-length pulse is 2 cycles", lo, 2);
            chk("R3 pulse length", lo, VEC_LO[i]);
            chk("R5 startup gap", su, 2);
            chk("R6 type held during pulse", mt, prev_type);
            chk("R6 type requested after release", int'(rst_type), 4);
            chk("R7 len kept through requested reset", int'(len_rd), int'(VEC_LEN[i]));
            prev_type = 4;
        end

        // R8: re-request in the middle of a pulse
        write_len(4'd2);
        run_req(1, 4, 4'd0, lo, su, mt);
        chk("R8 re-request mid pulse, length", lo, 8);
        chk("R8 re-request mid pulse, startup", su, 2);
        // R8: re-request during startup
        run_req(3, 0, 4'd0, lo, su, mt);
        chk("R8 re-request in startup, length", lo, 8);
        chk("R8 re-request in startup, startup", su, 2);
        chk("R8 no new pulse after startup request", int'(ext_rst_n), 1);

        // R9: length write in mid-pulse
        write_len(4'd3);
        run_req(2, 3, 4'd1, lo, su, mt);
        chk("R9 running pulse keeps old length", lo, 16);
        chk("R9 new length visible", int'(len_rd), 1);
        run_req(0, 0, 4'd0, lo, su, mt);
        chk("R9 new length applies to next pulse", lo, 4);

        // R7: general reset clears a programmed length, then the 2-cycle release
        write_len(4'd6);
        general_reset();
        release_general();
        chk("R7 len zero after general reset", int'(len_rd), 0);

        finish_run();
    end
endmodule